// File: doc/BRIEF.md
# SPI Command Slave for a Six-Channel Switch Controller

This block is the serial front end of a six-channel low-side switch controller. A host master sends 16-bit frames: a control byte, then a data byte, both MSB first. The slave accepts a frame only when the control byte starts with the device prefix. It decodes one of five operations and keeps two 6-bit configuration registers. One register picks parallel or serial control per channel. The other holds the serial on/off bits per channel. While the host shifts its frame in, the slave shifts diagnostic or register content out on SO.

SCLK, SI and CS_N come from the pads asynchronously. They are synchronised into a fast system clock, and all edges are detected in that clock domain. The system clock must run at least four times faster than SCLK.

A frame takes effect only when chip select is released and exactly sixteen falling SCLK edges were seen during the frame. On that release the block does one of two things. It either updates a register, or it issues a one-cycle clear strobe to the separate diagnostic capture block.

Top module: `spi_cmd_slave`

## Requirements
- R1: After synchronous reset, `mux_cfg` and `scon_cfg` are 6'h3F (they read back as FFh including two constant 1 bits), `so_oe` is 0 and no `diag_clr` pulse occurs.
- R2: `so_oe` is 0 whenever chip select is high. It is also 0 during the first two bit slots of every frame.
- R3: A frame whose control bits 7:6 are not 1,0 keeps `so_oe` at 0 for the whole frame. Such a frame changes no register and produces no `diag_clr`.
- R4: SI is captured at falling SCLK edges and SO is updated after rising SCLK edges, MSB first. After the k-th rising edge (k = 1..16), SO carries frame bit 16-k.
- R5: Bits 13..8 of the outgoing frame are, in order: the common fault flag, the common overtemperature flag, channel 6 status (`diag_stat[11:10]`), then channel 5 status (`diag_stat[9:8]`).
- R6: Bits 7..0 of the outgoing frame depend on the command. With code 0101 they are `{scon_cfg, 2'b11}`. With code 1001 they are `{mux_cfg, 2'b11}`. With any other code they are `diag_stat[7:0]` (channels 4..1, two bits each, channel n in bits 2n-1:2n-2).
- R7: Control bits 5:2 select the operation, and bits 1:0 are ignored. Code 0110 loads data bits 7:2 into `scon_cfg`. Code 1010 loads data bits 7:2 into `mux_cfg`. Either load happens only on chip-select release.
- R8: Code 0000 (diagnostic read) in a valid frame produces exactly one `diag_clr` pulse, one cycle wide, after chip-select release.
- R9: A frame with a falling-edge count other than 16 writes nothing and produces no `diag_clr`.
- R10: An unused code (any value other than 0000, 0101, 0110, 1001, 1010) writes nothing. For such a code, bits 7..0 return the channel 4..1 status, as for a diagnostic read.
- R11: The fault, overtemperature and status inputs are captured when chip select falls. Later input changes do not alter the SO content of that frame.
- R12: A read command (0101, 1001) ignores its data byte and leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the master, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the master |
| so_d | output | 1 | Serial data toward the master |
| so_oe | output | 1 | Output enable for the SO pad driver (0 = high impedance) |
| diag_fault_n | input | 1 | Common fault flag, 1 = no fault |
| diag_ot_n | input | 1 | Common overtemperature flag, 1 = none |
| diag_stat | input | 12 | Two status bits per channel, channel 6 in the top pair |
| mux_cfg | output | 6 | Per-channel parallel(1)/serial(0) select, channel 6 at bit 5 |
| scon_cfg | output | 6 | Per-channel serial on/off bits, channel 6 at bit 5 |
| diag_clr | output | 1 | One-cycle clear strobe to the diagnostic block |

## Verification
The bench sends frames with 15, 16 and 17 clocks. A design that commits on "at least 16" would write registers or clear diagnostics on the long frame. The bench also sends an unaddressed write and an unaddressed diagnostic read. A slave that ignored the prefix would drive SO or change registers on those frames. Unused command codes are sent to catch a decoder that treats an unknown code as a write or returns register content. The diagnostic inputs are flipped in the middle of a frame. A slave that shifts live inputs instead of a snapshot then returns mixed data. Every SO bit is compared at the master's sampling point, which exposes a one-slot shift error or an output enabled during the two prefix slots.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int BYTE_BITS  = 8;
  localparam int NUM_CH     = 6;
  localparam int STAT_W     = 2 * NUM_CH;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int SNAP_W     = STAT_W + 2;

  localparam logic [1:0] DEV_PREFIX = 2'b10;

  localparam logic [3:0] OP_RD_DIAG = 4'b0000;
  localparam logic [3:0] OP_RD_SCON = 4'b0101;
  localparam logic [3:0] OP_WR_SCON = 4'b0110;
  localparam logic [3:0] OP_RD_MUX  = 4'b1001;
  localparam logic [3:0] OP_WR_MUX  = 4'b1010;

  typedef logic [NUM_CH-1:0] chan_vec_t;
endpackage

// File: rtl/spi_in_sync.sv
`timescale 1ns/1ps
module spi_in_sync #(
  parameter int              STAGES  = 2,
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [STAGES-1:0][W-1:0] stg;
  logic [W-1:0]             prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg  <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             bit_strobe,
  input  logic             si_bit,
  output logic             addr_ok,
  output logic [3:0]       cmd_code,
  output logic [CNT_W-1:0] fall_cnt,
  output chan_vec_t        mux_cfg,
  output chan_vec_t        scon_cfg,
  output logic             diag_clr
);
  logic [BYTE_BITS-1:0] rx;
  logic                 full_frame;

  assign full_frame = (fall_cnt == CNT_W'(FRAME_BITS)) && addr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx       <= '0;
      fall_cnt <= '0;
      addr_ok  <= 1'b0;
      cmd_code <= OP_RD_DIAG;
      mux_cfg  <= '1;
      scon_cfg <= '1;
      diag_clr <= 1'b0;
    end else begin
      diag_clr <= 1'b0;
      if (frame_start) begin
        fall_cnt <= '0;
        addr_ok  <= 1'b0;
        cmd_code <= OP_RD_DIAG;
      end else if (bit_strobe) begin
        rx <= {rx[BYTE_BITS-2:0], si_bit};
        if (fall_cnt != CNT_W'(FRAME_BITS + 1)) fall_cnt <= fall_cnt + 1'b1;
        if (fall_cnt == CNT_W'(1)) addr_ok <= ({rx[0], si_bit} == DEV_PREFIX);
        if (fall_cnt == CNT_W'(BYTE_BITS - 1)) cmd_code <= rx[4:1];
      end else if (frame_end && full_frame) begin
        case (cmd_code)
          OP_WR_SCON: scon_cfg <= rx[BYTE_BITS-1:2];
          OP_WR_MUX:  mux_cfg  <= rx[BYTE_BITS-1:2];
          OP_RD_DIAG: diag_clr <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    diag_clr |=> !diag_clr); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(mux_cfg) && $stable(scon_cfg))); // R7
  AST_CLR_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    $rose(diag_clr) |-> $past(frame_end)); // R8
endmodule

// File: rtl/spi_so_path.sv
`timescale 1ns/1ps
module spi_so_path
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              cs_act,
  input  logic              shift_strobe,
  input  logic              addr_ok,
  input  logic [3:0]        cmd_code,
  input  chan_vec_t         mux_cfg,
  input  chan_vec_t         scon_cfg,
  input  logic              fault_n,
  input  logic              ot_n,
  input  logic [STAT_W-1:0] stat,
  output logic              so_d,
  output logic              so_oe
);
  logic [SNAP_W-1:0]     snap;
  logic [CNT_W-1:0]      rcnt;
  logic [BYTE_BITS-1:0]  low_byte;
  logic [FRAME_BITS-1:0] word;
  logic [IDX_W-1:0]      bit_idx;

  always_comb begin
    case (cmd_code)
      OP_RD_SCON: low_byte = {scon_cfg, 2'b11};
      OP_RD_MUX:  low_byte = {mux_cfg, 2'b11};
      default:    low_byte = snap[BYTE_BITS-1:0];
    endcase
  end

  assign word    = {2'b11, snap[SNAP_W-1:BYTE_BITS], low_byte};
  assign bit_idx = IDX_W'(FRAME_BITS - 1) - rcnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      snap  <= '1;
      rcnt  <= '0;
      so_d  <= 1'b1;
      so_oe <= 1'b0;
    end else if (frame_start) begin
      snap  <= {fault_n, ot_n, stat};
      rcnt  <= '0;
      so_d  <= 1'b1;
      so_oe <= 1'b0;
    end else if (!cs_act) begin
      so_oe <= 1'b0;
    end else if (shift_strobe && (rcnt < CNT_W'(FRAME_BITS))) begin
      so_d  <= word[bit_idx];
      so_oe <= addr_ok && (rcnt >= CNT_W'(2));
      rcnt  <= rcnt + 1'b1;
    end
  end

  AST_SO_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !so_oe); // R2
  AST_SO_NEEDS_ADDR: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> addr_ok); // R3
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cs_act && !frame_start) |=> $stable(snap)); // R11
endmodule

// File: rtl/spi_cmd_slave.sv
`timescale 1ns/1ps
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  output logic              so_d,
  output logic              so_oe,
  input  logic              diag_fault_n,
  input  logic              diag_ot_n,
  input  logic [STAT_W-1:0] diag_stat,
  output logic [NUM_CH-1:0] mux_cfg,
  output logic [NUM_CH-1:0] scon_cfg,
  output logic              diag_clr
);
  localparam int PIN_CS = 0;
  localparam int PIN_CK = 1;
  localparam int PIN_SI = 2;

  logic [2:0]       pin_lvl, pin_rise, pin_fall;
  logic             cs_act, frame_start, frame_end, ck_rise, ck_fall;
  logic             addr_ok;
  logic [3:0]       cmd_code;
  logic [CNT_W-1:0] fall_cnt;
  chan_vec_t        mux_q, scon_q;

  spi_in_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b001)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_si, spi_sclk, spi_cs_n}),
    .lvl  (pin_lvl),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign cs_act      = ~pin_lvl[PIN_CS];
  assign frame_start = pin_fall[PIN_CS];
  assign frame_end   = pin_rise[PIN_CS];
  assign ck_rise     = pin_rise[PIN_CK] & cs_act;
  assign ck_fall     = pin_fall[PIN_CK] & cs_act;

  spi_frame_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .bit_strobe  (ck_fall),
    .si_bit      (pin_lvl[PIN_SI]),
    .addr_ok     (addr_ok),
    .cmd_code    (cmd_code),
    .fall_cnt    (fall_cnt),
    .mux_cfg     (mux_q),
    .scon_cfg    (scon_q),
    .diag_clr    (diag_clr)
  );

  spi_so_path u_so (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .cs_act       (cs_act),
    .shift_strobe (ck_rise),
    .addr_ok      (addr_ok),
    .cmd_code     (cmd_code),
    .mux_cfg      (mux_q),
    .scon_cfg     (scon_q),
    .fault_n      (diag_fault_n),
    .ot_n         (diag_ot_n),
    .stat         (diag_stat),
    .so_d         (so_d),
    .so_oe        (so_oe)
  );

  assign mux_cfg  = mux_q;
  assign scon_cfg = scon_q;

  AST_OE_AFTER_PREFIX: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (fall_cnt >= CNT_W'(2))); // R2
  AST_CLR_FULL_COUNT: assert property (@(posedge clk) disable iff (rst)
    diag_clr |-> (fall_cnt == CNT_W'(FRAME_BITS))); // R9
endmodule

// File: tb/test_spi_cmd_slave.sv
`timescale 1ns/1ps
module test_spi_cmd_slave;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic flt_n = 1'b1, ot_n = 1'b1;
  logic [11:0] stat = '1;
  logic so_d, so_oe, diag_clr;
  logic [5:0] mux_cfg, scon_cfg;

  int compared = 0, mismatched = 0, clr_seen = 0;
  logic [5:0] mux_m = '1, scon_m = '1;
  bit live = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_si(si),
    .so_d(so_d), .so_oe(so_oe), .diag_fault_n(flt_n), .diag_ot_n(ot_n),
    .diag_stat(stat), .mux_cfg(mux_cfg), .scon_cfg(scon_cfg), .diag_clr(diag_clr)
  );

  always @(posedge clk) if (diag_clr) clr_seen++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (live) begin
    check(mux_cfg == mux_m, "R7 live mux_cfg", 32'(mux_cfg), 32'(mux_m));
    check(scon_cfg == scon_m, "R7 live scon_cfg", 32'(scon_cfg), 32'(scon_m));
    check(so_oe == 1'b0, "R2 idle so_oe", 32'(so_oe), 0);
  end

  task automatic run_frame(input logic [15:0] w, input int nclk, input bit chg);
    logic [13:0] snap;
    logic        addr, exp_oe;
    logic [3:0]  code;
    logic [7:0]  sec;
    logic [15:0] word;
    bit          known;
    int          clr0, exp_clr;
    string       tg;
    snap  = {flt_n, ot_n, stat};
    addr  = (w[15:14] == 2'b10);
    code  = w[13:10];
    known = (code == 4'b0000) || (code == 4'b0101) || (code == 4'b0110) ||
            (code == 4'b1001) || (code == 4'b1010);
    if (code == 4'b0101)      sec = {scon_m, 2'b11};
    else if (code == 4'b1001) sec = {mux_m, 2'b11};
    else                      sec = snap[7:0];
    word = {2'b11, snap[13:8], sec};
    live = 1'b0;
    clr0 = clr_seen;
    @(negedge clk); cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      repeat (H/2) @(negedge clk);
      si = (i < 16) ? w[15-i] : 1'b0;
      repeat (H/2) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i < 16) begin
        exp_oe = addr && (i >= 2);
        if (i < 2)       tg = "R2";
        else if (!addr)  tg = "R3";
        else if (i < 8)  tg = "R5";
        else if (known)  tg = "R6";
        else             tg = "R10";
        if (chg && i > 4) tg = {tg, " R11"};
        check(so_oe == exp_oe, $sformatf("%s R4 so_oe slot %0d", tg, i), 32'(so_oe), 32'(exp_oe));
        if (exp_oe)
          check(so_d == word[15-i], $sformatf("%s R4 so_d slot %0d", tg, i), 32'(so_d), 32'(word[15-i]));
      end
      sclk = 1'b0;
      if (chg && i == 4) begin
        flt_n = ~flt_n; ot_n = ~ot_n; stat = ~stat;
      end
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4*H) @(negedge clk);
    if (nclk == 16 && addr) begin
      if (code == 4'b0110) scon_m = w[7:2];
      if (code == 4'b1010) mux_m  = w[7:2];
    end
    exp_clr = (nclk == 16 && addr && code == 4'b0000) ? 1 : 0;
    check(clr_seen - clr0 == exp_clr, $sformatf("R8 R9 clear pulses cmd %0h clocks %0d", w[15:8], nclk),
          32'(clr_seen - clr0), 32'(exp_clr));
    check(mux_cfg == mux_m, $sformatf("R7 R9 R10 R12 mux_cfg after %0h", w[15:8]), 32'(mux_cfg), 32'(mux_m));
    check(scon_cfg == scon_m, $sformatf("R7 R9 R10 R12 scon_cfg after %0h", w[15:8]), 32'(scon_cfg), 32'(scon_m));
    live = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(mux_cfg == 6'h3F, "R1 reset mux_cfg", 32'(mux_cfg), 32'h3F);
    check(scon_cfg == 6'h3F, "R1 reset scon_cfg", 32'(scon_cfg), 32'h3F);
    check(so_oe == 1'b0, "R1 reset so_oe", 32'(so_oe), 0);
    check(clr_seen == 0, "R1 reset diag_clr", 32'(clr_seen), 0);
    live = 1'b1;
    repeat (10) @(negedge clk);

    flt_n = 1'b0; ot_n = 1'b1; stat = 12'b01_00_10_11_01_10;
    run_frame({8'h80, 8'h00}, 16, 1'b0);   // R8 diagnostic read
    run_frame({8'h98, 8'hA5}, 16, 1'b0);   // R7 write serial bits
    run_frame({8'h94, 8'hFF}, 16, 1'b0);   // R12 read serial bits
    run_frame({8'hA8, 8'h3C}, 16, 1'b0);   // R7 write mux
    stat = 12'hA5C; ot_n = 1'b0; flt_n = 1'b1;
    run_frame({8'hA4, 8'h00}, 16, 1'b0);   // R12 read mux
    run_frame({8'h18, 8'h00}, 16, 1'b0);   // R3 unaddressed write
    run_frame({8'hC0, 8'h00}, 16, 1'b0);   // R3 unaddressed read
    run_frame({8'h98, 8'h00}, 15, 1'b0);   // R9 short write
    run_frame({8'hA8, 8'hFC}, 17, 1'b0);   // R9 long write
    run_frame({8'h80, 8'h00}, 15, 1'b0);   // R9 short diagnostic read
    run_frame({8'hBC, 8'h00}, 16, 1'b0);   // R10 unused code
    run_frame({8'h84, 8'hFF}, 16, 1'b0);   // R10 unused code
    stat = 12'h3C6; flt_n = 1'b0; ot_n = 1'b1;
    run_frame({8'h80, 8'h00}, 16, 1'b1);   // R11 inputs change mid-frame
    run_frame({8'h9B, 8'h54}, 16, 1'b0);   // R7 don't-care low control bits

    live = 1'b0;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    repeat (5) @(negedge clk);
    mux_m = '1; scon_m = '1;
    check(mux_cfg == 6'h3F, "R1 re-reset mux_cfg", 32'(mux_cfg), 32'h3F);
    check(scon_cfg == 6'h3F, "R1 re-reset scon_cfg", 32'(scon_cfg), 32'h3F);
    live = 1'b1;
    repeat (10) @(negedge clk);
    live = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog timeout, all requirements, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule